// File: doc/BRIEF.md
# Per-Block Security Access Filter

This block sits between a bus master and a downstream memory port and admits or refuses each access according to a one-bit-per-block security table. The protected region is cut into equal power-of-two blocks. Each table bit says which security world may touch that block: a set bit admits only non-secure traffic, and a clear bit admits only secure traffic. An admitted access is handed to the downstream port unchanged, and its response comes back to the master.

A refused access never reaches memory. A refused read returns zero, and a refused write is discarded. The response carries an error flag only when the error-reporting configuration input is high. The first refusal after the status flag was last cleared latches the full address, the master ID, the effective non-secure attribute and the table bit, and then raises the status flag. Later refusals leave that record alone until software clears the flag.

The table is loaded one 32-bit word at a time through a simple write port, and reset clears it to all zeros. Block size, region size, address width and master-ID width are elaboration parameters. The table depth is derived from them.

Top module: `sec_block_filter`

## Requirements
- R1: Block number = address >> log2(BLOCK_BYTES). The table word holding it is (block number >> 5), and the bit inside that word is (block number & 31).
- R2: An access passes when the table bit equals the effective non-secure attribute. Bit 1 admits only non-secure accesses, and bit 0 admits only secure ones.
- R3: When `up_attr_known` is 0 the access is treated as secure (effective non-secure = 0), whatever `up_nonsec` carries.
- R4: A refused access issues no downstream request. A refused read returns all-zero data, and a refused write leaves memory unchanged.
- R5: `up_rsp_err` is 1 only for a refused access, and only when `cfg_err_resp` was 1 at acceptance. Admitted accesses always respond with error 0.
- R6: A refusal while `irq_status` is 0 does three things. It loads `cap_addr` with the full address. It loads `cap_info` with the master ID in [15:0], the effective non-secure attribute in bit 16 and the table bit in bit 17, with all other bits 0. It sets `irq_status` on the accepting edge.
- R7: While `irq_status` is 1, further refusals are still refused, but `cap_addr` and `cap_info` do not change.
- R8: A one-cycle `irq_clear` pulse returns `irq_status` to 0. The next refusal then captures afresh.
- R9: One transaction is handled at a time, and `up_req_ready` is high only when the filter is idle. An admitted request appears on the downstream port the cycle after acceptance and is held stable until `dn_req_ready`. A refused access responds the cycle after acceptance.
- R10: A table write with `lut_wr_en` stores `lut_wr_data` into word `lut_wr_idx`. Reset clears every table word to 0.
- R11: After reset, `up_req_ready` = 1, `up_rsp_valid` = 0, `dn_req_valid` = 0, `irq_status` = 0, and both capture outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_err_resp | input | 1 | Refused accesses respond with error when high |
| lut_wr_en | input | 1 | Table word write strobe |
| lut_wr_idx | input | IDX_W | Table word index |
| lut_wr_data | input | 32 | Table word value, one bit per block |
| irq_clear | input | 1 | Clears the violation status |
| irq_status | output | 1 | Violation status flag |
| cap_addr | output | ADDR_W | Address of the first captured refusal |
| cap_info | output | 32 | Master ID [15:0], non-secure bit 16, table bit 17 |
| up_req_valid | input | 1 | Master request valid |
| up_req_ready | output | 1 | Filter can accept a request |
| up_addr | input | ADDR_W | Byte address inside the region |
| up_write | input | 1 | 1 = write, 0 = read |
| up_wdata | input | DATA_W | Write data |
| up_attr_known | input | 1 | Security attribute is specified |
| up_nonsec | input | 1 | Non-secure attribute |
| up_mid | input | MID_W | Master ID |
| up_rsp_valid | output | 1 | One-cycle response strobe |
| up_rsp_rdata | output | DATA_W | Read data (0 for writes and refusals) |
| up_rsp_err | output | 1 | Error response |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream accepts request |
| dn_addr | output | ADDR_W | Downstream address |
| dn_write | output | 1 | Downstream write |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response strobe |
| dn_rsp_rdata | input | DATA_W | Downstream read data |

## Verification
The pass/refuse decision is driven with all four combinations of table bit and attribute. It is also driven with the unspecified attribute against both bit values, which separates the "treat as secure" rule from a plain use of the non-secure input. Addresses are chosen in blocks on both table words and in blocks next to a set bit, so a slip in block-number or word/bit extraction refuses the wrong block. Refused writes are followed by secure reads of the same word, and the downstream request count is compared against the model, which exposes any leak past the filter. Repeated refusals with and without an intervening status clear separate first-capture from overwrite behaviour. A downstream ready that stalls irregularly exercises the hold of the forwarded request.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RESP  = 2'd3
   } sfl_state_e;

   // capture record field positions (decoded by software)
   localparam int CAP_MID_LSB = 0;
   localparam int CAP_NS_BIT  = 16;
   localparam int CAP_LUT_BIT = 17;
   localparam int LUT_WORD_W  = 32;
   localparam int LUT_BIT_SEL = 5;
endpackage

// File: rtl/sfl_lut.sv
module sfl_lut #(
   parameter int DEPTH  = 2,
   parameter int IDX_W  = 1,
   parameter int RIDX_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [31:0]       wr_data,
   input  logic [RIDX_W-1:0] rd_idx,
   output logic [31:0]       rd_word
);
   logic [31:0] word_q [DEPTH];
   logic [31:0] sel_w  [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q[w] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(w))) begin
            word_q[w] <= wr_data;
         end
      end
      assign sel_w[w] = (rd_idx == RIDX_W'(w)) ? word_q[w] : '0;
   end

   always_comb begin
      rd_word = '0;
      for (int w = 0; w < DEPTH; w++) begin
         rd_word = rd_word | sel_w[w];
      end
   end
endmodule

// File: rtl/sfl_decide.sv
module sfl_decide #(
   parameter int BN_W = 25
) (
   input  logic [BN_W-1:0] blk_num,
   input  logic            attr_known,
   input  logic            nonsec,
   input  logic [31:0]     rd_word,
   output logic [BN_W-6:0] rd_idx,
   output logic            lut_bit,
   output logic            eff_nonsec,
   output logic            pass
);
   import sfl_pkg::*;

   assign rd_idx     = blk_num[BN_W-1:LUT_BIT_SEL];
   assign lut_bit    = rd_word[blk_num[LUT_BIT_SEL-1:0]];
   assign eff_nonsec = attr_known & nonsec;
   assign pass       = (lut_bit == eff_nonsec);
endmodule

// File: rtl/sfl_capture.sv
module sfl_capture #(
   parameter int ADDR_W = 32,
   parameter int MID_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt,
   input  logic [ADDR_W-1:0] evt_addr,
   input  logic [MID_W-1:0]  evt_mid,
   input  logic              evt_nonsec,
   input  logic              evt_lut_bit,
   input  logic              clr,
   output logic              status,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [31:0]       cap_info
);
   import sfl_pkg::*;

   logic [31:0] info_w;

   always_comb begin
      info_w = '0;
      info_w[CAP_MID_LSB +: 16] = 16'(evt_mid);
      info_w[CAP_NS_BIT]        = evt_nonsec;
      info_w[CAP_LUT_BIT]       = evt_lut_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status   <= 1'b0;
         cap_addr <= '0;
         cap_info <= '0;
      end else if (evt && !status) begin
         status   <= 1'b1;
         cap_addr <= evt_addr;
         cap_info <= info_w;
      end else if (clr) begin
         status   <= 1'b0;
      end
   end

   assert_status_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt && !status |=> status);

   assert_capture_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      status |=> $stable(cap_addr) && $stable(cap_info));

   assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !evt |=> !status);
endmodule

// File: rtl/sec_block_filter.sv
module sec_block_filter #(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 32,
   parameter int MID_W        = 16,
   parameter int REGION_BYTES = 8192,
   parameter int BLOCK_BYTES  = 128,
   localparam int BLK_SHIFT   = $clog2(BLOCK_BYTES),
   localparam int NUM_BLOCKS  = REGION_BYTES / BLOCK_BYTES,
   localparam int LUT_DEPTH   = (NUM_BLOCKS + 31) / 32,
   localparam int IDX_W       = (LUT_DEPTH > 1) ? $clog2(LUT_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_err_resp,
   input  logic              lut_wr_en,
   input  logic [IDX_W-1:0]  lut_wr_idx,
   input  logic [31:0]       lut_wr_data,
   input  logic              irq_clear,
   output logic              irq_status,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [31:0]       cap_info,
   input  logic              up_req_valid,
   output logic              up_req_ready,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic              up_write,
   input  logic [DATA_W-1:0] up_wdata,
   input  logic              up_attr_known,
   input  logic              up_nonsec,
   input  logic [MID_W-1:0]  up_mid,
   output logic              up_rsp_valid,
   output logic [DATA_W-1:0] up_rsp_rdata,
   output logic              up_rsp_err,
   output logic              dn_req_valid,
   input  logic              dn_req_ready,
   output logic [ADDR_W-1:0] dn_addr,
   output logic              dn_write,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_rsp_valid,
   input  logic [DATA_W-1:0] dn_rsp_rdata
);
   import sfl_pkg::*;

   localparam int BN_W   = ADDR_W - BLK_SHIFT;
   localparam int RIDX_W = BN_W - LUT_BIT_SEL;

   // elaboration-time parameter checks
   if (BLOCK_BYTES < 32 || (1 << BLK_SHIFT) != BLOCK_BYTES) begin : g_bad_block
      $error("BLOCK_BYTES must be a power of two of at least 32");
   end
   if (REGION_BYTES < BLOCK_BYTES || (REGION_BYTES % BLOCK_BYTES) != 0) begin : g_bad_region
      $error("REGION_BYTES must be a whole multiple of BLOCK_BYTES");
   end
   if (MID_W < 1 || MID_W > 16) begin : g_bad_mid
      $error("MID_W must lie in 1..16");
   end
   if (BN_W <= LUT_BIT_SEL) begin : g_bad_addr
      $error("ADDR_W too narrow for the chosen block size");
   end

   sfl_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic              write_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              pass_q;
   logic              err_q;

   logic              accept;
   logic [BN_W-1:0]   blk_num;
   logic [RIDX_W-1:0] lut_rd_idx;
   logic [31:0]       lut_rd_word;
   logic              lut_bit;
   logic              eff_nonsec;
   logic              pass;

   assign up_req_ready = (state_q == ST_IDLE);
   assign accept       = up_req_valid && up_req_ready;
   assign blk_num      = up_addr[ADDR_W-1:BLK_SHIFT];

   sfl_lut #(
      .DEPTH  (LUT_DEPTH),
      .IDX_W  (IDX_W),
      .RIDX_W (RIDX_W)
   ) u_lut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lut_wr_en),
      .wr_idx  (lut_wr_idx),
      .wr_data (lut_wr_data),
      .rd_idx  (lut_rd_idx),
      .rd_word (lut_rd_word)
   );

   sfl_decide #(
      .BN_W (BN_W)
   ) u_decide (
      .blk_num    (blk_num),
      .attr_known (up_attr_known),
      .nonsec     (up_nonsec),
      .rd_word    (lut_rd_word),
      .rd_idx     (lut_rd_idx),
      .lut_bit    (lut_bit),
      .eff_nonsec (eff_nonsec),
      .pass       (pass)
   );

   sfl_capture #(
      .ADDR_W (ADDR_W),
      .MID_W  (MID_W)
   ) u_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt         (accept && !pass),
      .evt_addr    (up_addr),
      .evt_mid     (up_mid),
      .evt_nonsec  (eff_nonsec),
      .evt_lut_bit (lut_bit),
      .clr         (irq_clear),
      .status      (irq_status),
      .cap_addr    (cap_addr),
      .cap_info    (cap_info)
   );

   // transaction sequencer: decision registered before downstream issue
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         write_q <= 1'b0;
         wdata_q <= '0;
         rdata_q <= '0;
         pass_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  addr_q  <= up_addr;
                  write_q <= up_write;
                  wdata_q <= up_wdata;
                  rdata_q <= '0;
                  pass_q  <= pass;
                  err_q   <= !pass && cfg_err_resp;
                  state_q <= pass ? ST_ISSUE : ST_RESP;
               end
            end
            ST_ISSUE: begin
               if (dn_req_ready) begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (dn_rsp_valid) begin
                  rdata_q <= write_q ? '0 : dn_rsp_rdata;
                  state_q <= ST_RESP;
               end
            end
            ST_RESP: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign dn_req_valid = (state_q == ST_ISSUE);
   assign dn_addr      = addr_q;
   assign dn_write     = write_q;
   assign dn_wdata     = wdata_q;
   assign up_rsp_valid = (state_q == ST_RESP);
   assign up_rsp_rdata = rdata_q;
   assign up_rsp_err   = err_q;

   assert_blocked_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      up_rsp_valid && !pass_q |-> up_rsp_rdata == '0);

   assert_no_dn_on_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !pass |=> !dn_req_valid);

   assert_err_only_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      up_rsp_valid && up_rsp_err |-> !pass_q);

   assert_unknown_secure_R3: assert property (@(posedge clk) disable iff (!rst_n)
      up_req_valid && !up_attr_known && !lut_bit |-> pass);

   assert_dn_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_addr)
                                        && $stable(dn_wdata) && $stable(dn_write));

   assert_issue_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      accept && pass |=> dn_req_valid);
endmodule

// File: tb/sim_sec_block_filter.sv
module sim_sec_block_filter;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_WORDS  = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_err_resp = 1'b0;
   logic        lut_wr_en = 1'b0;
   logic [0:0]  lut_wr_idx = '0;
   logic [31:0] lut_wr_data = '0;
   logic        irq_clear = 1'b0;
   logic        irq_status;
   logic [31:0] cap_addr;
   logic [31:0] cap_info;
   logic        up_req_valid = 1'b0;
   logic        up_req_ready;
   logic [31:0] up_addr = '0;
   logic        up_write = 1'b0;
   logic [31:0] up_wdata = '0;
   logic        up_attr_known = 1'b1;
   logic        up_nonsec = 1'b0;
   logic [15:0] up_mid = '0;
   logic        up_rsp_valid;
   logic [31:0] up_rsp_rdata;
   logic        up_rsp_err;
   logic        dn_req_valid;
   logic        dn_req_ready;
   logic [31:0] dn_addr;
   logic        dn_write;
   logic [31:0] dn_wdata;
   logic        dn_rsp_valid;
   logic [31:0] dn_rsp_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   sec_block_filter u0 (
      .clk(clk), .rst_n(rst_n), .cfg_err_resp(cfg_err_resp),
      .lut_wr_en(lut_wr_en), .lut_wr_idx(lut_wr_idx), .lut_wr_data(lut_wr_data),
      .irq_clear(irq_clear), .irq_status(irq_status),
      .cap_addr(cap_addr), .cap_info(cap_info),
      .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
      .up_addr(up_addr), .up_write(up_write), .up_wdata(up_wdata),
      .up_attr_known(up_attr_known), .up_nonsec(up_nonsec), .up_mid(up_mid),
      .up_rsp_valid(up_rsp_valid), .up_rsp_rdata(up_rsp_rdata), .up_rsp_err(up_rsp_err),
      .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
      .dn_addr(dn_addr), .dn_write(dn_write), .dn_wdata(dn_wdata),
      .dn_rsp_valid(dn_rsp_valid), .dn_rsp_rdata(dn_rsp_rdata)
   );

   // downstream memory with an irregular ready pattern
   logic [31:0] mem [MEM_WORDS];
   logic [31:0] cyc = '0;
   int          dn_seen = 0;
   always_ff @(posedge clk) cyc <= cyc + 1;
   assign dn_req_ready = (cyc % 3) != 1;
   always @(posedge clk) begin
      dn_rsp_valid <= 1'b0;
      if (dn_req_valid && dn_req_ready) begin
         dn_seen      <= dn_seen + 1;
         dn_rsp_valid <= 1'b1;
         dn_rsp_rdata <= mem[dn_addr[12:2]];
         if (dn_write) mem[dn_addr[12:2]] <= dn_wdata;
      end
   end

   // bench model
   logic [31:0] exp_mem [MEM_WORDS];
   logic [31:0] lut_m [2];
   logic        stat_m = 1'b0;
   logic [31:0] cap_addr_m = '0;
   logic [31:0] cap_info_m = '0;
   int          dn_exp = 0;
   int          checks = 0;
   int          failures = 0;

   typedef struct {
      logic [31:0] rdata;
      logic        err;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: pop and compare responses
   always @(negedge clk) begin
      if (rst_n && up_rsp_valid) begin
         if (sb_q.size() == 0) begin
            chk("R9", 32'd1, 32'd0, "unexpected response");
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.tag, up_rsp_rdata, e.rdata, "rdata");
            chk(e.tag, {31'd0, up_rsp_err}, {31'd0, e.err}, "err");
         end
      end
   end

   task automatic txn(input logic [31:0] a, input logic wr, input logic [31:0] wd,
                      input logic known, input logic ns, input logic [15:0] mid,
                      input string tag);
      int    blk;
      logic  bitv;
      logic  effns;
      logic  ok;
      exp_t  e;
      blk   = int'(a >> 7);
      bitv  = lut_m[blk >> 5][blk & 31];
      effns = known & ns;
      ok    = (bitv == effns);
      e.rdata = (ok && !wr) ? exp_mem[a[12:2]] : 32'd0;
      e.err   = !ok && cfg_err_resp;
      e.tag   = tag;
      if (ok) begin
         dn_exp++;
         if (wr) exp_mem[a[12:2]] = wd;
      end else if (!stat_m) begin
         stat_m     = 1'b1;
         cap_addr_m = a;
         cap_info_m = {14'd0, bitv, effns, mid};
      end
      sb_q.push_back(e);
      @(negedge clk);
      up_req_valid  = 1'b1;
      up_addr       = a;
      up_write      = wr;
      up_wdata      = wd;
      up_attr_known = known;
      up_nonsec     = ns;
      up_mid        = mid;
      while (!up_req_ready) @(negedge clk);
      @(negedge clk);
      up_req_valid = 1'b0;
      while (sb_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic chk_cap(input string req);
      chk(req, {31'd0, irq_status}, {31'd0, stat_m}, "irq_status");
      chk(req, cap_addr, cap_addr_m, "cap_addr");
      chk(req, cap_info, cap_info_m, "cap_info");
   endtask

   task automatic lut_write(input logic idx, input logic [31:0] d);
      @(negedge clk);
      lut_wr_en = 1'b1; lut_wr_idx = idx; lut_wr_data = d;
      @(negedge clk);
      lut_wr_en = 1'b0;
      lut_m[idx] = d;
   endtask

   task automatic do_clear();
      @(negedge clk); irq_clear = 1'b1;
      @(negedge clk); irq_clear = 1'b0;
      stat_m = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      lut_m[0] = '0; lut_m[1] = '0;
      stat_m = 1'b0; cap_addr_m = '0; cap_info_m = '0;
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < MEM_WORDS; i++) begin
         mem[i]     = 32'hC0DE_0000 ^ i;
         exp_mem[i] = 32'hC0DE_0000 ^ i;
      end
      lut_m[0] = '0; lut_m[1] = '0;
      do_reset();
      // R11: reset state
      chk("R11", {31'd0, up_req_ready}, 32'd1, "ready");
      chk("R11", {31'd0, up_rsp_valid}, 32'd0, "rsp_valid");
      chk("R11", {31'd0, dn_req_valid}, 32'd0, "dn_req_valid");
      chk_cap("R11");

      // R2: secure write on all-zero table passes
      txn(32'h100, 1'b1, 32'hA5A5_0001, 1'b1, 1'b0, 16'h0011, "R2");
      // R3: unspecified attribute with ns=1 still passes
      txn(32'h100, 1'b0, 32'h0, 1'b0, 1'b1, 16'h0012, "R3");
      // R4/R5/R6: non-secure read refused, zero data, no error
      txn(32'h100, 1'b0, 32'h0, 1'b1, 1'b1, 16'h0042, "R4");
      chk_cap("R6");
      // R7/R5: refused write with error reporting; capture held
      cfg_err_resp = 1'b1;
      txn(32'h104, 1'b1, 32'h0000_DEAD, 1'b1, 1'b1, 16'h0099, "R5");
      chk_cap("R7");
      chk("R4", dn_seen, dn_exp, "downstream count");
      // R4: refused write left memory intact
      txn(32'h104, 1'b0, 32'h0, 1'b1, 1'b0, 16'h0001, "R4");
      // R8: clear status
      do_clear();
      chk("R8", {31'd0, irq_status}, 32'd0, "irq_status after clear");

      // R10/R1: program both table words
      lut_write(1'b1, 32'h0000_0020);   // block 37
      lut_write(1'b0, 32'h0000_0008);   // block 3
      txn(32'h1284, 1'b1, 32'h1234_5678, 1'b1, 1'b1, 16'h0005, "R2");
      txn(32'h1284, 1'b0, 32'h0, 1'b1, 1'b0, 16'h0077, "R1");
      chk_cap("R8");
      txn(32'h1284, 1'b0, 32'h0, 1'b1, 1'b1, 16'h0006, "R1");
      txn(32'h1200, 1'b0, 32'h0, 1'b1, 1'b1, 16'h0007, "R1");
      chk_cap("R7");
      txn(32'h0180, 1'b0, 32'h0, 1'b1, 1'b1, 16'h0008, "R1");
      txn(32'h1284, 1'b0, 32'h0, 1'b0, 1'b1, 16'h0009, "R3");
      // R3/R6: fresh capture of an unspecified-attribute refusal
      do_clear();
      cfg_err_resp = 1'b0;
      txn(32'h1280, 1'b0, 32'h0, 1'b0, 1'b1, 16'h00AB, "R3");
      chk_cap("R6");
      chk("R4", dn_seen, dn_exp, "downstream count");

      // R10: reset clears the table, secure access to block 37 passes
      do_reset();
      chk_cap("R11");
      txn(32'h1284, 1'b0, 32'h0, 1'b1, 1'b0, 16'h0003, "R10");
      txn(32'h1284, 1'b0, 32'h0, 1'b1, 1'b1, 16'h0004, "R10");
      chk_cap("R10");
      chk("R9", {31'd0, up_req_ready}, 32'd1, "idle ready");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule